// File: doc/BRIEF.md
# GPIO Edge Timestamp Capture Unit

This block records the instant at which an external signal changes level. A free-running time base (a 32-bit seconds count and a 30-bit nanoseconds count) is presented on input ports. Each capture channel routes one of the GPIO lines to itself through a 4-bit map field. The routed line passes through a two-flop synchronizer. When the synchronized line shows an enabled rising or falling edge, the current time value is latched into that edge type's own timestamp store, and the matching status flag is set.

Software uses a 16-bit register port with a combinational read path. Through it, software programs the edge enables, the pin map, the channel selector and the interrupt gate. It also reads and clears the status flags and reads the four 16-bit time words of the selected channel. A level interrupt stays asserted while any enabled capture is pending and the interrupt gate is open.

Register addresses (4-bit):

| Address | Content |
|---|---|
| 0x0 | Control; bit 2 is the interrupt gate |
| 0x1 | Channel selector, bits [10:8] |
| 0x2 | Pin map; nibble [4n+3:4n] belongs to channel n |
| 0x3 | Edge enable; bit n is rise, bit n+8 is fall |
| 0x4 | Status, same layout as the edge enable |
| 0x8 to 0xB | Rising-edge words: seconds high, seconds low, nanoseconds high, nanoseconds low |
| 0xC to 0xF | Falling-edge words, in the same order |

Top module: `gpio_edge_tstamp`

## Requirements
- R1: After a synchronous reset every register address 0x0 to 0xF reads 0 and irq is 0.
- R2: A rising edge on the mapped pin of channel n, with edge enable bit n set, latches {time_sec, time_ns} on the third rising clock edge after the input change. It also sets status bit n.
- R3: A falling edge on the mapped pin of channel n, with edge enable bit n+8 set, latches the time into the falling-edge words (0xC to 0xF) on the third clock edge after the change, and sets status bit n+8. The rising-edge words are left unchanged.
- R4: An edge whose enable bit is clear sets no status bit and leaves that edge's timestamp words unchanged.
- R5: Map nibble [4n+3:4n] at address 0x2 selects which GPIO number feeds channel n.
- R6: An edge on a mapped pin whose pin_is_input bit is 0 is ignored: no status bit is set and the words are unchanged.
- R7: The nanoseconds-high word reads {2'b00, ns[29:16]}. The seconds-high, seconds-low and nanoseconds-low words read sec[31:16], sec[15:0] and ns[15:0].
- R8: Writing 1 to a status bit at 0x4 clears it. Writing 0 leaves it unchanged.
- R9: A new edge of the same type while its flag is set overwrites the timestamp with the new time, and the flag stays set.
- R10: irq equals control bit 2 ANDed with the OR, over all channels and both edge types, of the status bits whose edge enable bit is set.
- R11: The selector field at bits [10:8] of address 0x1 picks which channel's timestamp words appear at 0x8 to 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | NUM_GPIO | External GPIO levels (asynchronous) |
| pin_is_input | input | NUM_GPIO | 1 when the GPIO is configured as an input |
| time_sec | input | 32 | Time base, seconds |
| time_ns | input | 30 | Time base, nanoseconds |
| reg_addr | input | 4 | Register address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_data | output | 16 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
A wrong synchronizer depth or a wrong detection point moves the latched time by one or more counter steps. This shows in the captured words read just after the third clock edge, because the bench's time base changes every cycle. A status flag that fails to set, clears by itself or is cleared by the wrong write shows at once in the status read and on irq. A swapped edge type or channel index shows as data in the wrong word group, or as a selector read that returns the other channel's time.

// File: rtl/gts_pkg.sv
package gts_pkg;

    localparam int REG_W   = 16;
    localparam int SEC_W   = 32;
    localparam int NS_W    = 30;
    localparam int MAP_W   = 4;
    localparam int MAX_CH  = 4;
    localparam int SEL_W   = 3;
    localparam int SEL_LSB = 8;
    localparam int IE_BIT  = 2;
    localparam int FALL_OFS = 8;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_SEL  = 4'h1;
    localparam logic [3:0] A_MAP  = 4'h2;
    localparam logic [3:0] A_EN   = 4'h3;
    localparam logic [3:0] A_STS  = 4'h4;
    localparam logic [3:0] A_R_NSHI = 4'hA;
    localparam logic [3:0] A_F_NSHI = 4'hE;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tstamp_t;

    typedef enum logic [1:0] {
        W_SEC_HI = 2'd0,
        W_SEC_LO = 2'd1,
        W_NS_HI  = 2'd2,
        W_NS_LO  = 2'd3
    } ts_word_e;

    function automatic logic [REG_W-1:0] ts_word(tstamp_t t, ts_word_e w);
        logic [REG_W-1:0] r;
        case (w)
            W_SEC_HI: r = t.sec[31:16];
            W_SEC_LO: r = t.sec[15:0];
            W_NS_HI:  r = {2'b00, t.ns[29:16]};
            default:  r = t.ns[15:0];
        endcase
        return r;
    endfunction

    // one rise bit and one fall bit for every implemented channel
    function automatic logic [REG_W-1:0] pair_mask(int n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < n; i++) begin
            m[i]            = 1'b1;
            m[i + FALL_OFS] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [REG_W-1:0] low_mask(int bits);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < bits; i++) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/gts_edge_detect.sv
module gts_edge_detect
    import gts_pkg::*;
#(
    parameter int NUM_GPIO = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_GPIO-1:0] gpio_in,
    input  logic [NUM_GPIO-1:0] pin_is_input,
    input  logic [MAP_W-1:0]    pin_sel,
    output logic                rise,
    output logic                fall
);

    localparam int SYNC_STAGES = 2;

    logic raw;
    logic pin_ok;
    logic [SYNC_STAGES:0] shreg;   // [1:0] synchronizer, [2] previous level

    always_comb begin
        raw    = 1'b0;
        pin_ok = 1'b0;
        for (int i = 0; i < NUM_GPIO; i++) begin
            if (pin_sel == MAP_W'(i)) begin
                raw    = gpio_in[i];
                pin_ok = pin_is_input[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[SYNC_STAGES-1:0], raw};
    end

    assign rise = pin_ok &  shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
    assign fall = pin_ok & ~shreg[SYNC_STAGES-1] &  shreg[SYNC_STAGES];

endmodule

// File: rtl/gts_capture_bank.sv
module gts_capture_bank
    import gts_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cap_rise,
    input  logic    cap_fall,
    input  tstamp_t now,
    output tstamp_t rise_ts,
    output tstamp_t fall_ts
);

    // the whole stamp is one register per edge type, so all words move together
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_ts <= '0;
            fall_ts <= '0;
        end else begin
            if (cap_rise) rise_ts <= now;
            if (cap_fall) fall_ts <= now;
        end
    end

endmodule

// File: rtl/gts_regs.sv
module gts_regs
    import gts_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [3:0]              reg_addr,
    input  logic                    reg_wr_en,
    input  logic [REG_W-1:0]        reg_wr_data,
    output logic [REG_W-1:0]        reg_rd_data,
    input  logic [NUM_CH-1:0]       cap_rise,
    input  logic [NUM_CH-1:0]       cap_fall,
    input  tstamp_t [NUM_CH-1:0]    rise_ts,
    input  tstamp_t [NUM_CH-1:0]    fall_ts,
    output logic [NUM_CH*MAP_W-1:0] map_sel,
    output logic [NUM_CH-1:0]       en_rise,
    output logic [NUM_CH-1:0]       en_fall,
    output logic [NUM_CH-1:0]       sts_rise,
    output logic [NUM_CH-1:0]       sts_fall,
    output logic                    ie,
    output logic                    irq
);

    localparam logic [REG_W-1:0] CH_MASK  = pair_mask(NUM_CH);
    localparam logic [REG_W-1:0] MAP_MASK = low_mask(NUM_CH * MAP_W);

    logic                 ie_q;
    logic [SEL_W-1:0]     sel_q;
    logic [REG_W-1:0]     map_q;
    logic [REG_W-1:0]     en_q;
    logic [REG_W-1:0]     sts_q;
    logic [REG_W-1:0]     sts_set;
    logic [REG_W-1:0]     sts_clr;
    tstamp_t              rise_view;
    tstamp_t              fall_view;

    always_comb begin
        sts_set = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            sts_set[n]            = cap_rise[n];
            sts_set[n + FALL_OFS] = cap_fall[n];
        end
        sts_clr = (reg_wr_en && reg_addr == A_STS) ? (reg_wr_data & CH_MASK) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q  <= 1'b0;
            sel_q <= '0;
            map_q <= '0;
            en_q  <= '0;
            sts_q <= '0;
        end else begin
            if (reg_wr_en) begin
                case (reg_addr)
                    A_CTRL: ie_q  <= reg_wr_data[IE_BIT];
                    A_SEL:  sel_q <= reg_wr_data[SEL_LSB +: SEL_W];
                    A_MAP:  map_q <= reg_wr_data & MAP_MASK;
                    A_EN:   en_q  <= reg_wr_data & CH_MASK;
                    default: ;
                endcase
            end
            // a capture in the same cycle as a clear keeps the flag
            sts_q <= (sts_q & ~sts_clr) | sts_set;
        end
    end

    always_comb begin
        rise_view = '0;
        fall_view = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (sel_q == SEL_W'(n)) begin
                rise_view = rise_ts[n];
                fall_view = fall_ts[n];
            end
        end
    end

    always_comb begin
        reg_rd_data = '0;
        if (reg_addr[3]) begin
            reg_rd_data = ts_word(reg_addr[2] ? fall_view : rise_view,
                                  ts_word_e'(reg_addr[1:0]));
        end else begin
            case (reg_addr)
                A_CTRL:  reg_rd_data = REG_W'(ie_q) << IE_BIT;
                A_SEL:   reg_rd_data = REG_W'(sel_q) << SEL_LSB;
                A_MAP:   reg_rd_data = map_q;
                A_EN:    reg_rd_data = en_q;
                A_STS:   reg_rd_data = sts_q;
                default: reg_rd_data = '0;
            endcase
        end
    end

    always_comb begin
        for (int n = 0; n < NUM_CH; n++) begin
            en_rise[n]  = en_q[n];
            en_fall[n]  = en_q[n + FALL_OFS];
            sts_rise[n] = sts_q[n];
            sts_fall[n] = sts_q[n + FALL_OFS];
        end
    end

    assign map_sel = map_q[NUM_CH*MAP_W-1:0];
    assign ie      = ie_q;
    assign irq     = ie_q & (|(sts_q & en_q));

endmodule

// File: rtl/gpio_edge_tstamp.sv
module gpio_edge_tstamp
    import gts_pkg::*;
#(
    parameter int NUM_GPIO = 16,
    parameter int NUM_CH   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_GPIO-1:0] gpio_in,
    input  logic [NUM_GPIO-1:0] pin_is_input,
    input  logic [31:0]         time_sec,
    input  logic [29:0]         time_ns,
    input  logic [3:0]          reg_addr,
    input  logic                reg_wr_en,
    input  logic [15:0]         reg_wr_data,
    output logic [15:0]         reg_rd_data,
    output logic                irq
);

    tstamp_t                    now;
    tstamp_t [NUM_CH-1:0]       rise_ts;
    tstamp_t [NUM_CH-1:0]       fall_ts;
    logic [NUM_CH*MAP_W-1:0]    map_sel;
    logic [NUM_CH-1:0]          det_rise, det_fall;
    logic [NUM_CH-1:0]          cap_rise, cap_fall;
    logic [NUM_CH-1:0]          en_rise, en_fall;
    logic [NUM_CH-1:0]          sts_rise, sts_fall;
    logic                       ie;

    assign now.sec = time_sec;
    assign now.ns  = time_ns;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        gts_edge_detect #(.NUM_GPIO(NUM_GPIO)) u_det (
            .clk          (clk),
            .rst          (rst),
            .gpio_in      (gpio_in),
            .pin_is_input (pin_is_input),
            .pin_sel      (map_sel[n*MAP_W +: MAP_W]),
            .rise         (det_rise[n]),
            .fall         (det_fall[n])
        );

        assign cap_rise[n] = det_rise[n] & en_rise[n];
        assign cap_fall[n] = det_fall[n] & en_fall[n];

        gts_capture_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .cap_rise (cap_rise[n]),
            .cap_fall (cap_fall[n]),
            .now      (now),
            .rise_ts  (rise_ts[n]),
            .fall_ts  (fall_ts[n])
        );
    end

    gts_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .cap_rise    (cap_rise),
        .cap_fall    (cap_fall),
        .rise_ts     (rise_ts),
        .fall_ts     (fall_ts),
        .map_sel     (map_sel),
        .en_rise     (en_rise),
        .en_fall     (en_fall),
        .sts_rise    (sts_rise),
        .sts_fall    (sts_fall),
        .ie          (ie),
        .irq         (irq)
    );

endmodule

// File: rtl/gts_checker.sv
module gts_checker
    import gts_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic              ie,
    input logic [NUM_CH-1:0] en_rise,
    input logic [NUM_CH-1:0] en_fall,
    input logic [NUM_CH-1:0] sts_rise,
    input logic [NUM_CH-1:0] sts_fall,
    input logic [NUM_CH-1:0] cap_rise,
    input logic [NUM_CH-1:0] cap_fall,
    input logic [3:0]        reg_addr,
    input logic              reg_wr_en,
    input logic [15:0]       reg_rd_data
);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !ie |-> !irq);

    p_irq_source_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (((sts_rise & en_rise) | (sts_fall & en_fall)) != '0));

    p_nshi_pad_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_R_NSHI || reg_addr == A_F_NSHI) |-> reg_rd_data[15:14] == 2'b00);

    p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_en && reg_addr == A_STS) |=>
        (((sts_rise & $past(sts_rise)) == $past(sts_rise)) &&
         ((sts_fall & $past(sts_fall)) == $past(sts_fall))));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        p_rise_flag_r2: assert property (@(posedge clk) disable iff (rst)
            cap_rise[n] |=> sts_rise[n]);
        p_fall_flag_r3: assert property (@(posedge clk) disable iff (rst)
            cap_fall[n] |=> sts_fall[n]);
    end

endmodule

bind gpio_edge_tstamp gts_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq         (irq),
    .ie          (ie),
    .en_rise     (en_rise),
    .en_fall     (en_fall),
    .sts_rise    (sts_rise),
    .sts_fall    (sts_fall),
    .cap_rise    (cap_rise),
    .cap_fall    (cap_fall),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_data (reg_rd_data)
);

// File: tb/tb_gpio_edge_tstamp.sv
`timescale 1ns/1ps
module tb_gpio_edge_tstamp;

    localparam int NG = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NG-1:0] gpio_in = '0;
    logic [NG-1:0] pin_is_input = '1;
    logic [31:0]   tsec;
    logic [29:0]   tns;
    logic [3:0]    reg_addr = '0;
    logic          reg_wr_en = 1'b0;
    logic [15:0]   reg_wr_data = '0;
    logic [15:0]   reg_rd_data;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            tsec <= 32'h1234_5678;
            tns  <= 30'h3FFE_FF00;
        end else begin
            tsec <= tsec + 32'd3;
            tns  <= tns + 30'd13;
        end
    end

    gpio_edge_tstamp #(.NUM_GPIO(NG), .NUM_CH(2)) dut (
        .clk(clk), .rst(rst), .gpio_in(gpio_in), .pin_is_input(pin_is_input),
        .time_sec(tsec), .time_ns(tns), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rd_data;
    endtask

    // drive an edge, return the time the design is expected to latch
    task automatic make_edge(input int pin, input logic lvl,
                             output logic [31:0] es, output logic [29:0] en);
        @(negedge clk);
        gpio_in[pin] = lvl;
        @(posedge clk);
        @(posedge clk);
        #1 es = tsec; en = tns;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_words(input string tag, input logic [3:0] base,
                               input logic [31:0] es, input logic [29:0] en);
        logic [15:0] v;
        rd(base + 4'd0, v); chk({tag, " sec_hi"}, 32'(v), 32'(es[31:16]));
        rd(base + 4'd1, v); chk({tag, " sec_lo"}, 32'(v), 32'(es[15:0]));
        rd(base + 4'd2, v); chk({tag, " ns_hi R7"}, 32'(v), 32'({2'b00, en[29:16]}));
        rd(base + 4'd3, v); chk({tag, " ns_lo"}, 32'(v), 32'(en[15:0]));
    endtask

    // [11:10] channel, [9:6] gpio, [5] rise enable, [4] fall enable,
    // [3] 1 = rising edge, [2] pin is input, [1] capture expected
    localparam int NV = 6;
    localparam logic [11:0] VEC [NV] = '{
        {2'd0, 4'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {2'd0, 4'd3,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {2'd1, 4'd9,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {2'd1, 4'd9,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {2'd0, 4'd12, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd1, 4'd0,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R1 act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [31:0] es, es2;
        logic [29:0] en, en2;
        logic [15:0] old [4];

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk($sformatf("R1 reset addr %0d", a), 32'(v), 32'h0);
        end
        chk("R1 reset irq", 32'(irq), 32'h0);

        for (int i = 0; i < NV; i++) begin
            int ch, pin;
            logic ren, fen, is_rise, pin_in, exp_cap;
            logic [3:0] base;
            string tag;
            ch      = int'(VEC[i][11:10]);
            pin     = int'(VEC[i][9:6]);
            ren     = VEC[i][5];
            fen     = VEC[i][4];
            is_rise = VEC[i][3];
            pin_in  = VEC[i][2];
            exp_cap = VEC[i][1];
            base    = is_rise ? 4'h8 : 4'hC;
            tag = exp_cap ? (is_rise ? "R2 R5" : "R3 R5") : (pin_in ? "R4" : "R6");
            tag = $sformatf("%s R11 vec%0d", tag, i);

            wr(4'h3, 16'h0);
            gpio_in = '0;
            pin_is_input = '1;
            if (!pin_in) pin_is_input[pin] = 1'b0;
            idle(4);
            wr(4'h2, (ch == 0) ? {8'h00, 4'hF, 4'(pin)} : {8'h00, 4'(pin), 4'hF});
            wr(4'h1, 16'(ch) << 8);
            if (!is_rise) begin
                gpio_in[pin] = 1'b1;
                idle(4);
            end
            wr(4'h4, 16'hFFFF);
            wr(4'h3, (16'(ren) << ch) | (16'(fen) << (8 + ch)));
            for (int w = 0; w < 4; w++) rd(base + 4'(w), old[w]);

            make_edge(pin, is_rise, es, en);

            rd(4'h4, v);
            chk({tag, " status"}, 32'(v),
                exp_cap ? (is_rise ? (32'h1 << ch) : (32'h1 << (8 + ch))) : 32'h0);
            if (exp_cap) begin
                check_words(tag, base, es, en);
            end else begin
                for (int w = 0; w < 4; w++) begin
                    rd(base + 4'(w), v);
                    chk($sformatf("%s unchanged word %0d", tag, w), 32'(v), 32'(old[w]));
                end
            end
            chk({tag, " irq off R10"}, 32'(irq), 32'h0);
        end

        // R9: repeated rising edge overwrites and keeps the flag
        wr(4'h3, 16'h0);
        gpio_in = '0;
        pin_is_input = '1;
        idle(4);
        wr(4'h2, 16'h00F3);
        wr(4'h1, 16'h0000);
        wr(4'h4, 16'hFFFF);
        wr(4'h3, 16'h0001);
        make_edge(3, 1'b1, es, en);
        make_edge(3, 1'b0, es2, en2);
        idle(3);
        make_edge(3, 1'b1, es2, en2);
        rd(4'h4, v);
        chk("R9 flag kept", 32'(v), 32'h0001);
        check_words("R9 overwrite", 4'h8, es2, en2);
        rd(4'hA, v);
        chk("R7 ns_hi top bits zero", 32'(v[15:14]), 32'h0);

        // R10: interrupt gating
        chk("R10 gate closed", 32'(irq), 32'h0);
        wr(4'h0, 16'h0004);
        #1 chk("R10 gate open", 32'(irq), 32'h1);
        wr(4'h3, 16'h0000);
        #1 chk("R10 enable cleared", 32'(irq), 32'h0);
        rd(4'h4, v);
        chk("R10 flag remains", 32'(v), 32'h0001);
        wr(4'h3, 16'h0001);
        #1 chk("R10 enable restored", 32'(irq), 32'h1);

        // R8: write one to clear
        wr(4'h4, 16'h0000);
        rd(4'h4, v);
        chk("R8 zero write keeps", 32'(v), 32'h0001);
        wr(4'h4, 16'h0001);
        rd(4'h4, v);
        chk("R8 one write clears", 32'(v), 32'h0000);
        #1 chk("R8 R10 irq drops", 32'(irq), 32'h0);

        // R1: reset in the middle of operation
        make_edge(3, 1'b0, es, en);
        make_edge(3, 1'b1, es, en);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(4'h4, v);
        chk("R1 reset clears status", 32'(v), 32'h0);
        rd(4'h9, v);
        chk("R1 reset clears words", 32'(v), 32'h0);
        rd(4'h0, v);
        chk("R1 reset clears control", 32'(v), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule